// File: doc/BRIEF.md
# Event Channel Configuration Register Bank

This block holds the configuration of twelve event-routing channels as a bank of 32-bit registers behind a simple single-cycle read/write port. Each channel register carries a generator select, a path choice (synchronous, resynchronized or asynchronous), an edge-detection mode, a run-in-standby flag and an on-demand clock flag. The bank decodes the request address, applies reset values that depend on the channel index, and continuously drives each field to the channel logic as packed per-channel vectors.

The first eight channels support every path. The last four support only the asynchronous path, so their path field is fixed, and their standby and on-demand flags are held at zero both in readback and on the outputs. Each access carries a security flag. A non-secure access to a channel is honoured only when that channel's bit in an attribution input vector is set. A refused access reads zero, changes nothing and raises an error pulse. Software writes a register as one complete 32-bit word.

Top module: `evcfg_bank`

## Requirements
- R1: Channel n (0 to 11) decodes at byte address 0x20 + 8*n. A request to any other address returns read data zero, writes nothing and raises no error.
- R2: After reset, channels 0 to 7 read 0x00008000 and drive on-demand high. Channels 8 to 11 read 0x00000200, which is the asynchronous path code and nothing else.
- R3: Register fields are: generator select in bits 6:0, path in bits 9:8 (0 synchronous, 1 resynchronized, 2 asynchronous, 3 reserved), edge mode in bits 11:10, run-in-standby in bit 14 and on-demand in bit 15. All other bits read zero whatever was written.
- R4: On channels 8 to 11, writes to path, run-in-standby and on-demand are ignored. These read back as 2, 0 and 0 and are driven as 2, 0 and 0. Generator select and edge mode are stored normally.
- R5: A write whose path field is 3 leaves the stored path unchanged, while the other fields of that write take effect.
- R6: A non-secure request to channel n whose attribution bit n is 0 is refused. A refused read returns zero, a refused write changes no state, and access_err is high for exactly the one cycle after the request.
- R7: A non-secure request to channel n whose attribution bit n is 1 behaves like a secure one. Secure requests ignore the attribution vector.
- R8: Each channel's fields are driven at slice n of the per-channel output vectors (width times n upward), and a write is visible on them in the cycle after the request.
- R9: rd_data carries the read result in the cycle after a read request and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 32 | Write data, full register |
| req_nonsec | input | 1 | Request is non-secure |
| ns_attr | input | NUM_CH (12) | Per-channel non-secure attribution, 1 = non-secure allowed |
| rd_data | output | 32 | Read result, one cycle after the request |
| access_err | output | 1 | One-cycle pulse for a refused request |
| ch_gen | output | NUM_CH*7 | Generator select per channel |
| ch_path | output | NUM_CH*2 | Path code per channel |
| ch_edge | output | NUM_CH*2 | Edge mode per channel |
| ch_stdby | output | NUM_CH | Run-in-standby per channel |
| ch_ondemand | output | NUM_CH | On-demand clock per channel |

## Verification
The properties assume that the request inputs are valid and stable around the rising clock edge, and that reset is held for at least one edge before any request. They also assume that a write's address and data refer to a single register. The bench changes every input only on the falling edge and holds reset for several cycles with the port idle. It issues one request at a time and leaves an idle cycle between requests, so no property sees a request overlap the one before it.

// File: rtl/evcfg_pkg.sv
`timescale 1ns/1ps
package evcfg_pkg;
   localparam int GEN_W     = 7;
   localparam int GEN_LSB   = 0;
   localparam int PATH_LSB  = 8;
   localparam int EDGE_LSB  = 10;
   localparam int STDBY_BIT = 14;
   localparam int OD_BIT    = 15;

   typedef enum logic [1:0] {
      PATH_SYNC   = 2'd0,
      PATH_RESYNC = 2'd1,
      PATH_ASYNC  = 2'd2,
      PATH_RSVD   = 2'd3
   } path_e;

   typedef struct packed {
      logic             ondemand;
      logic             stdby;
      logic [1:0]       edge_mode;
      path_e            path;
      logic [GEN_W-1:0] gen;
   } chcfg_t;

   function automatic logic [31:0] cfg_to_word(input chcfg_t c);
      logic [31:0] w;
      w = '0;
      w[GEN_LSB +: GEN_W] = c.gen;
      w[PATH_LSB +: 2]    = c.path;
      w[EDGE_LSB +: 2]    = c.edge_mode;
      w[STDBY_BIT]        = c.stdby;
      w[OD_BIT]           = c.ondemand;
      return w;
   endfunction

   function automatic chcfg_t word_to_cfg(input logic [31:0] w);
      chcfg_t c;
      c.gen       = w[GEN_LSB +: GEN_W];
      c.path      = path_e'(w[PATH_LSB +: 2]);
      c.edge_mode = w[EDGE_LSB +: 2];
      c.stdby     = w[STDBY_BIT];
      c.ondemand  = w[OD_BIT];
      return c;
   endfunction
endpackage

// File: rtl/evcfg_decode.sv
`timescale 1ns/1ps
module evcfg_decode #(
   parameter int ADDR_W = 8,
   parameter int NUM_CH = 12,
   parameter int BASE   = 32,
   parameter int STRIDE = 8,
   localparam int SHIFT = $clog2(STRIDE),
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   logic [ADDR_W-1:0] off;
   logic              unused_off;

   assign off = addr - ADDR_W'(BASE);
   assign hit = (addr >= ADDR_W'(BASE)) &&
                (off < ADDR_W'(NUM_CH * STRIDE)) &&
                (off[SHIFT-1:0] == '0);
   assign idx = off[SHIFT +: IDX_W];
   assign unused_off = ^off;
endmodule

// File: rtl/evcfg_chreg.sv
`timescale 1ns/1ps
module evcfg_chreg
   import evcfg_pkg::*;
#(
   parameter bit ASYNC_ONLY = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_en,
   input  chcfg_t wr_cfg,
   output chcfg_t cfg
);
   generate
      if (ASYNC_ONLY) begin : g_async
         logic [GEN_W-1:0] gen_q;
         logic [1:0]       edge_q;
         logic             unused_fields;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               gen_q  <= '0;
               edge_q <= '0;
            end else if (wr_en) begin
               gen_q  <= wr_cfg.gen;
               edge_q <= wr_cfg.edge_mode;
            end
         end

         always_comb begin
            cfg.gen       = gen_q;
            cfg.edge_mode = edge_q;
            cfg.path      = PATH_ASYNC;
            cfg.stdby     = 1'b0;
            cfg.ondemand  = 1'b0;
         end
         assign unused_fields = ^{wr_cfg.path, wr_cfg.stdby, wr_cfg.ondemand};
      end else begin : g_full
         chcfg_t q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q.gen       <= '0;
               q.edge_mode <= '0;
               q.path      <= PATH_SYNC;
               q.stdby     <= 1'b0;
               q.ondemand  <= 1'b1;
            end else if (wr_en) begin
               q.gen       <= wr_cfg.gen;
               q.edge_mode <= wr_cfg.edge_mode;
               q.stdby     <= wr_cfg.stdby;
               q.ondemand  <= wr_cfg.ondemand;
               if (wr_cfg.path != PATH_RSVD)
                  q.path <= wr_cfg.path;
            end
         end
         assign cfg = q;
      end
   endgenerate
endmodule

// File: rtl/evcfg_bank.sv
`timescale 1ns/1ps
module evcfg_bank
   import evcfg_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_CH  = 12,
   parameter int SYNC_CH = 8,
   parameter int BASE    = 32,
   parameter int STRIDE  = 8,
   localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [31:0]               req_wdata,
   input  logic                      req_nonsec,
   input  logic [NUM_CH-1:0]         ns_attr,
   output logic [31:0]               rd_data,
   output logic                      access_err,
   output logic [NUM_CH*GEN_W-1:0]   ch_gen,
   output logic [NUM_CH*2-1:0]       ch_path,
   output logic [NUM_CH*2-1:0]       ch_edge,
   output logic [NUM_CH-1:0]         ch_stdby,
   output logic [NUM_CH-1:0]         ch_ondemand
);
   generate
      if (SYNC_CH > NUM_CH) begin : g_bad_sync
         $error("SYNC_CH must not exceed NUM_CH");
      end
      if ((1 << $clog2(STRIDE)) != STRIDE || STRIDE < 4) begin : g_bad_stride
         $error("STRIDE must be a power of two of at least 4");
      end
      if (BASE + NUM_CH * STRIDE > (1 << ADDR_W)) begin : g_bad_span
         $error("register span does not fit in ADDR_W");
      end
   endgenerate

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic             attr_sel;
   logic             allowed;
   logic             wr_ok;
   logic [31:0]      rd_sel;
   chcfg_t           wr_cfg;
   chcfg_t           cfg [NUM_CH];
   logic             unused_wdata;

   evcfg_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CH (NUM_CH),
      .BASE   (BASE),
      .STRIDE (STRIDE)
   ) u_decode (
      .addr (req_addr),
      .hit  (hit),
      .idx  (idx)
   );

   assign wr_cfg       = word_to_cfg(req_wdata);
   assign unused_wdata = ^{req_wdata[31:16], req_wdata[13:12], req_wdata[7]};

   always_comb begin
      attr_sel = 1'b0;
      rd_sel   = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (idx == IDX_W'(i)) begin
            attr_sel = ns_attr[i];
            rd_sel   = cfg_to_word(cfg[i]);
         end
      end
   end

   assign allowed = !req_nonsec || attr_sel;
   assign wr_ok   = req_valid && req_write && hit && allowed;

   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
         evcfg_chreg #(
            .ASYNC_ONLY (ch >= SYNC_CH)
         ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_ok && (idx == IDX_W'(ch))),
            .wr_cfg (wr_cfg),
            .cfg    (cfg[ch])
         );
         assign ch_gen[ch*GEN_W +: GEN_W] = cfg[ch].gen;
         assign ch_path[ch*2 +: 2]        = cfg[ch].path;
         assign ch_edge[ch*2 +: 2]        = cfg[ch].edge_mode;
         assign ch_stdby[ch]              = cfg[ch].stdby;
         assign ch_ondemand[ch]           = cfg[ch].ondemand;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data    <= '0;
         access_err <= 1'b0;
      end else begin
         rd_data    <= (req_valid && !req_write && hit && allowed) ? rd_sel : '0;
         access_err <= req_valid && hit && !allowed;
      end
   end
endmodule

// File: rtl/evcfg_bank_chk.sv
`timescale 1ns/1ps
module evcfg_bank_chk
   import evcfg_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_CH  = 12,
   parameter int SYNC_CH = 8,
   parameter int BASE    = 32,
   parameter int STRIDE  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_write,
   input logic [ADDR_W-1:0]       req_addr,
   input logic [31:0]             req_wdata,
   input logic                    req_nonsec,
   input logic [NUM_CH-1:0]       ns_attr,
   input logic [31:0]             rd_data,
   input logic                    access_err,
   input logic [NUM_CH*GEN_W-1:0] ch_gen,
   input logic [NUM_CH*2-1:0]     ch_path,
   input logic [NUM_CH*2-1:0]     ch_edge,
   input logic [NUM_CH-1:0]       ch_stdby,
   input logic [NUM_CH-1:0]       ch_ondemand
);
   int          rel;
   logic        hit_c;
   logic        attr_c;
   logic        blocked_c;
   logic        unused_chk;

   always_comb begin
      rel    = int'(req_addr) - BASE;
      hit_c  = (rel >= 0) && (rel < NUM_CH * STRIDE) && (rel % STRIDE == 0);
      attr_c = 1'b0;
      for (int i = 0; i < NUM_CH; i++)
         if (hit_c && rel == i * STRIDE) attr_c = ns_attr[i];
      blocked_c = req_valid && req_nonsec && hit_c && !attr_c;
   end
   assign unused_chk = ^{req_wdata[31:10], req_wdata[7:0]};

   // R6: refused request gives an error pulse next cycle
   a_r6_err_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
      blocked_c |=> access_err);
   a_r6_no_err_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !blocked_c |=> !access_err);
   // R6: refused read returns zero
   a_r6_refused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      blocked_c && !req_write |=> rd_data == '0);
   // R6: refused write changes no output
   a_r6_refused_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
      blocked_c && req_write |=> $stable(ch_gen) && $stable(ch_path) &&
      $stable(ch_edge) && $stable(ch_stdby) && $stable(ch_ondemand));
   // R1: unmapped address is silent
   a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !hit_c |=> !access_err && rd_data == '0);
   // R9: no read request, zero read data
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> rd_data == '0);
   // R5: reserved path code keeps every path
   a_r5_rsvd_path_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_wdata[9:8] == 2'b11 |=> $stable(ch_path));
   // R4: async-only channels never change path, standby or on-demand
   a_r4_async_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> $stable(ch_path[NUM_CH*2-1:SYNC_CH*2]) &&
      $stable(ch_stdby[NUM_CH-1:SYNC_CH]) && $stable(ch_ondemand[NUM_CH-1:SYNC_CH]));
endmodule

bind evcfg_bank evcfg_bank_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_CH  (NUM_CH),
   .SYNC_CH (SYNC_CH),
   .BASE    (BASE),
   .STRIDE  (STRIDE)
) u_chk (.*);

// File: tb/evcfg_bank_test.sv
`timescale 1ns/1ps
module evcfg_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_nonsec = 1'b0;
   logic [11:0] ns_attr = '0;
   logic [31:0] rd_data;
   logic        access_err;
   logic [83:0] ch_gen;
   logic [23:0] ch_path;
   logic [23:0] ch_edge;
   logic [11:0] ch_stdby;
   logic [11:0] ch_ondemand;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   evcfg_bank uut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_nonsec (req_nonsec),
      .ns_attr (ns_attr), .rd_data (rd_data), .access_err (access_err),
      .ch_gen (ch_gen), .ch_path (ch_path), .ch_edge (ch_edge),
      .ch_stdby (ch_stdby), .ch_ondemand (ch_ondemand)
   );

   // {write, nonsec, addr, wdata, attr, expected rd_data, expected err}
   typedef struct packed {
      logic        wr;
      logic        ns;
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic [11:0] attr;
      logic [31:0] exp_rd;
      logic        exp_err;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 8'h20, 32'h0,        12'h000, 32'h00008000, 1'b0}, // R2 ch0
      '{1'b0, 1'b0, 8'h78, 32'h0,        12'h000, 32'h00000200, 1'b0}, // R2 ch11
      '{1'b1, 1'b0, 8'h38, 32'hFFFFC9FF, 12'h000, 32'h0,        1'b0}, // R3 ch3 write
      '{1'b0, 1'b0, 8'h38, 32'h0,        12'h000, 32'h0000C97F, 1'b0}, // R3 reserved bits zero
      '{1'b1, 1'b0, 8'h68, 32'h0000C97F, 12'h000, 32'h0,        1'b0}, // R4 ch9 write
      '{1'b0, 1'b0, 8'h68, 32'h0,        12'h000, 32'h00000A7F, 1'b0}, // R4 ch9 readback
      '{1'b1, 1'b0, 8'h38, 32'h00000305, 12'h000, 32'h0,        1'b0}, // R5 path code 3
      '{1'b0, 1'b0, 8'h38, 32'h0,        12'h000, 32'h00000105, 1'b0}, // R5 path kept
      '{1'b0, 1'b1, 8'h30, 32'h0,        12'h000, 32'h0,        1'b1}, // R6 refused read
      '{1'b1, 1'b1, 8'h20, 32'h00000412, 12'h000, 32'h0,        1'b1}, // R6 refused write
      '{1'b0, 1'b0, 8'h20, 32'h0,        12'h000, 32'h00008000, 1'b0}, // R6 write ignored
      '{1'b1, 1'b1, 8'h20, 32'h00000412, 12'h001, 32'h0,        1'b0}, // R7 allowed write
      '{1'b0, 1'b1, 8'h20, 32'h0,        12'h001, 32'h00000412, 1'b0}, // R7 allowed read
      '{1'b0, 1'b0, 8'h20, 32'h0,        12'h000, 32'h00000412, 1'b0}, // R7 secure ignores attr
      '{1'b0, 1'b0, 8'h24, 32'h0,        12'h000, 32'h0,        1'b0}, // R1 misaligned
      '{1'b0, 1'b0, 8'h80, 32'h0,        12'h000, 32'h0,        1'b0}, // R1 past last channel
      '{1'b0, 1'b1, 8'h10, 32'h0,        12'h000, 32'h0,        1'b0}, // R1 below base, no error
      '{1'b0, 1'b0, 8'h58, 32'h0,        12'h000, 32'h00008000, 1'b0}  // R2 ch7
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic op(input logic wr, input logic ns, input logic [7:0] addr,
                     input logic [31:0] wdata, input logic [11:0] attr);
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_nonsec = ns;
      req_addr   = addr;
      req_wdata  = wdata;
      ns_attr    = attr;
      @(negedge clk);
      req_valid  = 1'b0;
      req_write  = 1'b0;
      req_nonsec = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset outputs
      check("R2 rd_data after reset", rd_data, 32'h0);
      check("R2 err after reset", {31'b0, access_err}, 32'h0);
      check("R2 ondemand after reset", {20'b0, ch_ondemand}, 32'h000000FF);
      check("R2 path after reset", {8'b0, ch_path}, 32'h00AA0000);
      check("R2 gen after reset", ch_gen[31:0], 32'h0);

      for (int v = 0; v < NV; v++) begin
         op(VEC[v].wr, VEC[v].ns, VEC[v].addr, VEC[v].wdata, VEC[v].attr);
         if (!VEC[v].wr)
            check($sformatf("vector %0d rd_data", v), rd_data, VEC[v].exp_rd);
         check($sformatf("vector %0d access_err", v), {31'b0, access_err},
               {31'b0, VEC[v].exp_err});
      end

      // R8 per-channel output slices
      check("R8 ch3 gen", {25'b0, ch_gen[21 +: 7]}, 32'h5);
      check("R8 ch3 path", {30'b0, ch_path[6 +: 2]}, 32'h1);
      check("R8 ch0 gen", {25'b0, ch_gen[0 +: 7]}, 32'h12);
      check("R8 ch0 edge", {30'b0, ch_edge[0 +: 2]}, 32'h1);
      check("R4 ch9 path out", {30'b0, ch_path[18 +: 2]}, 32'h2);
      check("R4 ch9 edge out", {30'b0, ch_edge[18 +: 2]}, 32'h2);
      check("R4 ch9 stdby/ondemand out", {30'b0, ch_stdby[9], ch_ondemand[9]}, 32'h0);

      // R8 write visible the cycle after the request
      op(1'b1, 1'b0, 8'h48, 32'h00004C33, 12'h000);
      check("R8 ch5 gen next cycle", {25'b0, ch_gen[35 +: 7]}, 32'h33);
      check("R8 ch5 edge", {30'b0, ch_edge[10 +: 2]}, 32'h3);
      check("R8 ch5 stdby/ondemand", {30'b0, ch_stdby[5], ch_ondemand[5]}, 32'h2);

      // R6 error lasts one cycle
      op(1'b0, 1'b1, 8'h28, 32'h0, 12'hFFD);
      check("R6 err pulse", {31'b0, access_err}, 32'h1);
      @(negedge clk);
      check("R6 err dropped", {31'b0, access_err}, 32'h0);

      // R9 read data only in the cycle after a read
      op(1'b0, 1'b0, 8'h48, 32'h0, 12'h000);
      check("R9 read result", rd_data, 32'h00004C33);
      @(negedge clk);
      check("R9 zero when idle", rd_data, 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule